// File: doc/BRIEF.md
# Instruction Breakpoint Comparator Unit

This block watches the instruction fetch address on every clock and signals a breakpoint hit when any armed comparator matches it. Each comparator holds a word-aligned code address and a two-bit halfword selector, so a breakpoint can be set on the lower halfword, the upper halfword or both halfwords of that word. Matches are only possible in the lowest 512 MB of the address map. A code address here has its top three bits at zero.

Software reaches the unit through a 32-bit register port addressed by byte offset. The control word is at offset 0. It holds a master enable. Writes to it take effect only when a key bit is set in the written data. The control word also reports how many comparators the unit has. Comparator words follow at offset 8, 12, 16 and onward, one word per comparator. The hit output is registered, so the core sees the hit one cycle after the fetch address.

Top module: `ibkpt_unit`

## Requirements
- R1: After a synchronous reset the master enable and every comparator enable are 0 and `bkpt_hit` is 0. The control word at offset 0 then reads as the comparator count in bits [7:4], with all other bits 0.
- R2: Bits [7:4] of the control word always read as the number of comparators (parameter `NUM_CMP`, 1 to 15). Bits [31:8] and [3:1] read 0.
- R3: A write to offset 0 changes the master enable (bit 0) only if bit 1 of the written data is 1. If bit 1 is 0, the write is ignored. Bit 1 always reads as 0.
- R4: Comparator n sits at byte offset 8 + 4n. It stores the mode in bits [31:30], the address in bits [28:2] and the enable in bit 0. It reads these fields back in the same positions. Bits 29 and 1 read as 0.
- R5: The mode field selects which halfwords match. 00 matches nothing, 01 matches the lower halfword (fetch bit 1 = 0), 10 matches the upper halfword (fetch bit 1 = 1), and 11 matches both.
- R6: A hit requires the master enable to be 1 and the matching comparator's enable to be 1.
- R7: A hit requires fetch address bits [31:29] to be zero and fetch bits [28:2] to equal the comparator's stored address.
- R8: `bkpt_hit` is registered. It rises at the clock edge that samples a matching fetch address, and it is a single bit high even when several comparators match.
- R9: Offset 4 and offsets past the last comparator read as 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | OFF_W | Register byte offset (bits [1:0] ignored) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| fetch_addr | input | 32 | Instruction fetch address |
| bkpt_hit | output | 1 | Registered breakpoint hit |

## Verification
There are two latencies to check. A register write takes effect at the clock edge that samples the strobe, and its readback is combinational from that point on. A hit is due one edge after the fetch address is applied. The bench therefore drives every input on the falling edge. It samples reads shortly after that falling edge, and it samples `bkpt_hit` at the next falling edge. One directed test also samples `bkpt_hit` before the capturing edge, to confirm the output has not yet risen at that point.

// File: rtl/ibkpt_pkg.sv
package ibkpt_pkg;

    typedef enum logic [1:0] {
        HW_NONE  = 2'b00,
        HW_LOWER = 2'b01,
        HW_UPPER = 2'b10,
        HW_BOTH  = 2'b11
    } hw_sel_t;

    localparam int CODE_ADDR_W  = 27;
    localparam int CMP_BASE_IDX = 2;
    localparam int KEY_BIT      = 1;

    typedef struct packed {
        hw_sel_t                  sel;
        logic [CODE_ADDR_W-1:0]   addr;
        logic                     en;
    } cmp_cfg_t;

    function automatic logic hw_allowed(hw_sel_t sel, logic upper);
        case (sel)
            HW_LOWER: hw_allowed = !upper;
            HW_UPPER: hw_allowed = upper;
            HW_BOTH:  hw_allowed = 1'b1;
            default:  hw_allowed = 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] pack_cfg(cmp_cfg_t c);
        pack_cfg = {c.sel, 1'b0, c.addr, 1'b0, c.en};
    endfunction

endpackage

// File: rtl/ibkpt_regbank.sv
module ibkpt_regbank
    import ibkpt_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int OFF_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wen,
    input  logic [OFF_W-1:0]     reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 glob_en_o,
    output cmp_cfg_t [NUM_CMP-1:0] cfg_o
);
    localparam int IDX_W = OFF_W - 2;
    localparam logic [IDX_W-1:0] END_IDX = IDX_W'(CMP_BASE_IDX + NUM_CMP);
    localparam logic [3:0] COUNT_FIELD = 4'(NUM_CMP);

    logic [IDX_W-1:0] idx;
    assign idx = reg_addr[OFF_W-1:2];

    logic unused_ok;
    assign unused_ok = ^{reg_addr[1:0], reg_wdata[29]};

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en_o <= 1'b0;
        end else if (reg_wen && idx == '0 && reg_wdata[KEY_BIT]) begin
            glob_en_o <= reg_wdata[0];
        end
    end

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp_reg
        cmp_cfg_t cfg_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q <= '0;
            end else if (reg_wen && idx == IDX_W'(CMP_BASE_IDX + i)) begin
                cfg_q.sel  <= hw_sel_t'(reg_wdata[31:30]);
                cfg_q.addr <= reg_wdata[28:2];
                cfg_q.en   <= reg_wdata[0];
            end
        end
        assign cfg_o[i] = cfg_q;
    end

    always_comb begin
        reg_rdata = '0;
        if (idx == '0) begin
            reg_rdata = {24'b0, COUNT_FIELD, 3'b0, glob_en_o};
        end
        for (int i = 0; i < NUM_CMP; i++) begin
            if (idx == IDX_W'(CMP_BASE_IDX + i)) begin
                reg_rdata = pack_cfg(cfg_o[i]);
            end
        end
    end

    // R3
    key_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wen && idx == '0 && !reg_wdata[KEY_BIT]) |=> $stable(glob_en_o));

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wen && (idx == IDX_W'(1) || idx >= END_IDX))
        |=> ($stable(glob_en_o) && $stable(cfg_o)));

endmodule

// File: rtl/ibkpt_comparator.sv
module ibkpt_comparator
    import ibkpt_pkg::*;
(
    input  cmp_cfg_t     cfg,
    input  logic         unit_en,
    input  logic [31:0]  fetch_addr,
    output logic         match
);
    logic in_code;
    logic addr_eq;
    logic unused_ok;

    assign unused_ok = fetch_addr[0];
    assign in_code   = (fetch_addr[31:29] == 3'b000);
    assign addr_eq   = (fetch_addr[28:2] == cfg.addr);
    assign match     = unit_en && cfg.en && in_code && addr_eq
                       && hw_allowed(cfg.sel, fetch_addr[1]);
endmodule

// File: rtl/ibkpt_unit.sv
module ibkpt_unit
    import ibkpt_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int OFF_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wen,
    input  logic [OFF_W-1:0]  reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       fetch_addr,
    output logic              bkpt_hit
);
    logic                   glob_en;
    cmp_cfg_t [NUM_CMP-1:0] cfg;
    logic [NUM_CMP-1:0]     match_vec;
    logic [NUM_CMP-1:0]     cmp_en_vec;

    ibkpt_regbank #(.NUM_CMP(NUM_CMP), .OFF_W(OFF_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .glob_en_o (glob_en),
        .cfg_o     (cfg)
    );

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        ibkpt_comparator cmp_i (
            .cfg        (cfg[i]),
            .unit_en    (glob_en),
            .fetch_addr (fetch_addr),
            .match      (match_vec[i])
        );
        assign cmp_en_vec[i] = cfg[i].en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bkpt_hit <= 1'b0;
        end else begin
            bkpt_hit <= |match_vec;
        end
    end

    // R6
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        bkpt_hit |-> ($past(glob_en) && $past(cmp_en_vec) != '0));

    // R7
    hit_code_region_chk: assert property (@(posedge clk) disable iff (rst)
        bkpt_hit |-> ($past(fetch_addr[31:29]) == 3'b000));

endmodule

// File: tb/ibkpt_unit_tb.sv
`timescale 1ns/1ps
module ibkpt_unit_tb_top;
    localparam int NUM_CMP = 4;
    localparam int OFF_W   = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wen = 1'b0;
    logic [OFF_W-1:0] reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [31:0]      fetch_addr = '0;
    logic             bkpt_hit;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ibkpt_unit #(.NUM_CMP(NUM_CMP), .OFF_W(OFF_W)) dut_i (
        .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fetch_addr(fetch_addr), .bkpt_hit(bkpt_hit)
    );

    // {expected hit, fetch address}
    localparam logic [32:0] VEC [0:9] = '{
        {1'b1, 32'h0000_1000},   // R5 both, lower
        {1'b1, 32'h0000_1002},   // R5 both, upper
        {1'b1, 32'h0000_2000},   // R5 lower only
        {1'b0, 32'h0000_2002},
        {1'b0, 32'h0000_3000},   // R5 upper only
        {1'b1, 32'h0000_3002},
        {1'b0, 32'h0000_4000},   // R5 mode 00
        {1'b0, 32'h0000_4002},
        {1'b0, 32'h0000_1004},   // R7 address differs
        {1'b0, 32'h2000_1000}    // R7 outside code region
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [OFF_W-1:0] off, logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = off; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [OFF_W-1:0] off, logic [31:0] exp);
        @(negedge clk);
        reg_addr = off;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic fetch_chk(string req, logic [31:0] a, logic exp);
        @(negedge clk);
        fetch_addr = a;
        @(negedge clk);
        chk(req, {31'b0, bkpt_hit}, {31'b0, exp});
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 / R2 reset state and count field
        rd_chk("R1", 8'd0, 32'h0000_0040);
        rd_chk("R1", 8'd8, 32'h0000_0000);
        chk("R1", {31'b0, bkpt_hit}, 32'h0);

        // R4 program comparators, read back with bits 29 and 1 dropped
        wr(8'd8,  32'hE000_1003);
        wr(8'd12, 32'h4000_2001);
        wr(8'd16, 32'h8000_3001);
        wr(8'd20, 32'h0000_4001);
        rd_chk("R4", 8'd8,  32'hC000_1001);
        rd_chk("R4", 8'd12, 32'h4000_2001);
        rd_chk("R4", 8'd16, 32'h8000_3001);
        rd_chk("R4", 8'd20, 32'h0000_4001);

        // R6 no hit with master disabled
        fetch_chk("R6", 32'h0000_1000, 1'b0);

        // R3 write without key ignored
        wr(8'd0, 32'h0000_0001);
        rd_chk("R3", 8'd0, 32'h0000_0040);
        fetch_chk("R3", 32'h0000_1000, 1'b0);
        wr(8'd0, 32'h0000_0003);
        rd_chk("R3", 8'd0, 32'h0000_0041);
        rd_chk("R2", 8'd0, 32'h0000_0041);

        for (int k = 0; k < 10; k++) begin
            fetch_chk("R5/R7 vector", VEC[k][31:0], VEC[k][32]);
        end
        fetch_chk("R7", 32'h8000_1002, 1'b0);

        // R6 comparator enable cleared
        wr(8'd8, 32'hC000_1000);
        fetch_chk("R6", 32'h0000_1000, 1'b0);
        wr(8'd8, 32'hC000_1001);

        // R9 unmapped offsets
        wr(8'd4, 32'hFFFF_FFFF);
        rd_chk("R9", 8'd4, 32'h0);
        wr(8'd24, 32'hFFFF_FFFF);
        rd_chk("R9", 8'd24, 32'h0);
        rd_chk("R9", 8'd0, 32'h0000_0041);
        rd_chk("R9", 8'd20, 32'h0000_4001);

        // R8 latency and multi-match single pulse
        wr(8'd20, 32'hC000_1001);
        fetch_chk("R8", 32'h0000_1004, 1'b0);
        @(negedge clk);
        fetch_addr = 32'h0000_1000;
        #1;
        chk("R8 before edge", {31'b0, bkpt_hit}, 32'h0);
        @(negedge clk);
        chk("R8 after edge", {31'b0, bkpt_hit}, 32'h1);
        fetch_chk("R8", 32'h0000_1004, 1'b0);

        // R1 reset mid-run
        fetch_addr = 32'h0000_1000;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 hit", {31'b0, bkpt_hit}, 32'h0);
        rd_chk("R1", 8'd0, 32'h0000_0040);
        rd_chk("R1", 8'd8, 32'h0000_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule